// File: doc/BRIEF.md
# In-Place Bubble Sort Engine

This block reorders N unsigned words, held in an external single-port RAM, into ascending order without any second buffer. After a start pulse, a control state machine walks an outer limit downward from N and sweeps an inner position upward from 2. At each position it compares the element just below the position with the element at the position and, when the lower one is larger, exchanges the two through a holding register.

Every state lasts exactly one clock and touches at most one RAM location. The RAM has a registered read path with one cycle of latency, so each operand is captured one state after its address is presented. The same address port carries reads and writes, steered by a select between the two neighbouring locations, and the write data comes either from the captured upper operand or from the holding register. When the outer limit is used up the engine raises a done flag and holds it until the next start.

Top module: `bsort_engine`

## Requirements
- R1: After reset, and until the first start pulse, `done` is 0 and `mem_we` is 0.
- R2: After a start pulse, once `done` is 1, address k holds the k-th smallest of the original words (unsigned, ascending by address, address 0 smallest), and no location is written while `done` is 1.
- R3: A pair whose lower-addressed word is less than or equal to the upper one is never exchanged; a fully ascending input, including one with all words equal, causes no write at all.
- R4: The number of write cycles in one complete sort equals twice the number of inversions of the original contents (pairs at addresses p<q whose word at p exceeds the word at q).
- R5: Every exchange is two consecutive write cycles: first address k receives the old word of k+1, then address k+1 receives the old word of k, so the second write's data is strictly greater than the first; the cycle after the second write has no write.
- R6: `done` stays 1 while `start` is 0, and goes to 0 in the cycle after `start` is sampled high.
- R7: A start pulse in any state restarts the sort from its clearing state; the contents at `done` are then sorted as in R2.
- R8: With `start` sampled high at one clock edge, `done` rises after exactly 2 + sum over i=2..N of (5i-2) + 3*X further edges, where X is the number of exchanges (the inversion count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts (or restarts) a sort when sampled high |
| mem_addr | output | $clog2(N) | RAM address for the current read or write |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | W | RAM write data |
| mem_rdata | input | W | RAM read data, valid one cycle after its address |
| done | output | 1 | High while the RAM contents are sorted and the engine is parked |

## Verification
The hardest situation to reach from the ports is a restart that lands in the middle of an exchange, after the lower location has been overwritten but before the upper one has been, which leaves a duplicated word and a lost word in RAM. The stimulus issues a second start pulse a fixed, odd number of cycles into a random sort, so that the engine is cut off mid-pass, and then checks that the final contents are an ascending copy of whatever the RAM held at the restart. Cycle-exact completion times and write counts are computed from inversion counts of random, reversed, duplicate-heavy and constant inputs.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR,
        ST_OTEST,
        ST_ITEST,
        ST_RD_HI,
        ST_CAP_HI,
        ST_CAP_LO,
        ST_HOLD,
        ST_WR_LO,
        ST_WR_HI,
        ST_STEP,
        ST_PASS,
        ST_DONE
    } sort_state_e;

    typedef struct packed {
        logic clr;
        logic hi_load;
        logic lo_load;
        logic hold_load;
        logic we;
        logic sel_lo;
        logic sel_hi;
        logic wsel_hold;
        logic step;
        logic pass_end;
        logic done;
    } sort_ctl_t;

endpackage

// File: rtl/bsort_index.sv
module bsort_index #(
    parameter int N  = 16,
    parameter int IW = 5,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic          pass_end,
    output logic          outer_done,
    output logic          inner_done,
    output logic [AW-1:0] addr_hi,
    output logic [AW-1:0] addr_lo
);

    localparam logic [IW-1:0] LIMIT_INIT = IW'(N);
    localparam logic [IW-1:0] POS_INIT   = IW'(2);

    typedef struct packed {
        logic [IW-1:0] limit;
        logic [IW-1:0] pos;
    } idx_t;

    idx_t idx_d, idx_q;
    logic [IW-1:0] pos_m1, pos_m2;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d.limit = LIMIT_INIT;
            idx_d.pos   = POS_INIT;
        end else if (pass_end) begin
            idx_d.limit = idx_q.limit - IW'(1);
            idx_d.pos   = POS_INIT;
        end else if (step) begin
            idx_d.pos   = idx_q.pos + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q.limit <= LIMIT_INIT;
            idx_q.pos   <= POS_INIT;
        end else begin
            idx_q <= idx_d;
        end
    end

    // element numbers run from 1; address = element - 1
    assign pos_m1     = idx_q.pos - IW'(1);
    assign pos_m2     = idx_q.pos - IW'(2);
    assign addr_hi    = pos_m1[AW-1:0];
    assign addr_lo    = pos_m2[AW-1:0];
    assign outer_done = (idx_q.limit < IW'(2));
    assign inner_done = (idx_q.pos > idx_q.limit);

endmodule

// File: rtl/bsort_operands.sv
module bsort_operands #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         hi_load,
    input  logic         lo_load,
    input  logic         hold_load,
    input  logic         wsel_hold,
    input  logic [W-1:0] rdata,
    output logic         lo_gt_hi,
    output logic [W-1:0] wdata
);

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic [W-1:0] hold;
    } opr_t;

    opr_t opr_d, opr_q;

    always_comb begin
        opr_d = opr_q;
        if (clr) begin
            opr_d = '0;
        end else begin
            if (hi_load)   opr_d.hi   = rdata;
            if (lo_load)   opr_d.lo   = rdata;
            if (hold_load) opr_d.hold = opr_q.lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opr_q <= '0;
        end else begin
            opr_q <= opr_d;
        end
    end

    // lower word arrives on rdata in the capture-and-compare state
    assign lo_gt_hi = (rdata > opr_q.hi);
    assign wdata    = wsel_hold ? opr_q.hold : opr_q.hi;

endmodule

// File: rtl/bsort_ctrl.sv
module bsort_ctrl
    import bsort_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      outer_done,
    input  logic      inner_done,
    input  logic      lo_gt_hi,
    output sort_ctl_t ctl
);

    sort_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CLR: begin
                ctl.clr = 1'b1;
                state_d = ST_OTEST;
            end
            ST_OTEST: state_d = outer_done ? ST_DONE : ST_ITEST;
            ST_ITEST: state_d = inner_done ? ST_PASS : ST_RD_HI;
            ST_RD_HI: begin
                ctl.sel_hi = 1'b1;
                state_d    = ST_CAP_HI;
            end
            ST_CAP_HI: begin
                ctl.hi_load = 1'b1;
                ctl.sel_lo  = 1'b1;
                state_d     = ST_CAP_LO;
            end
            ST_CAP_LO: begin
                ctl.lo_load = 1'b1;
                state_d     = lo_gt_hi ? ST_HOLD : ST_STEP;
            end
            ST_HOLD: begin
                ctl.hold_load = 1'b1;
                state_d       = ST_WR_LO;
            end
            ST_WR_LO: begin
                ctl.sel_lo = 1'b1;
                ctl.we     = 1'b1;
                state_d    = ST_WR_HI;
            end
            ST_WR_HI: begin
                ctl.sel_hi    = 1'b1;
                ctl.wsel_hold = 1'b1;
                ctl.we        = 1'b1;
                state_d       = ST_STEP;
            end
            ST_STEP: begin
                ctl.step = 1'b1;
                state_d  = ST_ITEST;
            end
            ST_PASS: begin
                ctl.pass_end = 1'b1;
                state_d      = ST_OTEST;
            end
            ST_DONE: ctl.done = 1'b1;
            default: state_d = ST_IDLE;
        endcase
        if (start) state_d = ST_CLR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/bsort_engine.sv
module bsort_engine
    import bsort_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic [$clog2(N)-1:0] mem_addr,
    output logic                 mem_we,
    output logic [W-1:0]         mem_wdata,
    input  logic [W-1:0]         mem_rdata,
    output logic                 done
);

    localparam int AW = $clog2(N);
    localparam int IW = $clog2(N + 2);

    sort_ctl_t     ctl;
    logic          outer_done, inner_done, lo_gt_hi;
    logic [AW-1:0] addr_hi, addr_lo;

    bsort_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .outer_done (outer_done),
        .inner_done (inner_done),
        .lo_gt_hi   (lo_gt_hi),
        .ctl        (ctl)
    );

    bsort_index #(.N(N), .IW(IW), .AW(AW)) index_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctl.clr),
        .step       (ctl.step),
        .pass_end   (ctl.pass_end),
        .outer_done (outer_done),
        .inner_done (inner_done),
        .addr_hi    (addr_hi),
        .addr_lo    (addr_lo)
    );

    bsort_operands #(.W(W)) operands_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctl.clr),
        .hi_load   (ctl.hi_load),
        .lo_load   (ctl.lo_load),
        .hold_load (ctl.hold_load),
        .wsel_hold (ctl.wsel_hold),
        .rdata     (mem_rdata),
        .lo_gt_hi  (lo_gt_hi),
        .wdata     (mem_wdata)
    );

    always_comb begin
        if (ctl.sel_lo)      mem_addr = addr_lo;
        else if (ctl.sel_hi) mem_addr = addr_hi;
        else                 mem_addr = '0;
    end

    assign mem_we = ctl.we;
    assign done   = ctl.done;

endmodule

// File: rtl/bsort_engine_chk.sv
module bsort_engine_chk #(
    parameter int W = 8,
    parameter int N = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [$clog2(N)-1:0] mem_addr,
    input logic                 mem_we,
    input logic [W-1:0]         mem_wdata,
    input logic                 done
);

    localparam int AW = $clog2(N);

    a_r1_r2_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    a_r5_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we) && !start) |=>
            (mem_we && mem_addr == $past(mem_addr) + AW'(1)));

    a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we) && !start) |=> (mem_wdata > $past(mem_wdata)));

    a_r5_pair_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |=> !mem_we);

endmodule

bind bsort_engine bsort_engine_chk #(.W(W), .N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .done      (done)
);

// File: tb/bsort_engine_tb_top.sv
module bsort_engine_tb_top;

    localparam int W  = 8;
    localparam int N  = 16;
    localparam int AW = $clog2(N);
    localparam int WAIT_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata;
    logic          done;

    logic [W-1:0]  ram [N];
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [W-1:0]  ld_data = '0;

    logic [W-1:0]  orig    [N];
    logic [W-1:0]  ref_arr [N];

    int n_chk = 0, n_err = 0;
    int mon_chk = 0, mon_err = 0, wr_cnt = 0;
    logic mon_clr = 1'b1;
    logic          prev_we = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic [W-1:0]  prev_data = '0;

    always #2 clk = ~clk;

    bsort_engine #(.W(W), .N(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done)
    );

    // single-port RAM model, registered read
    always @(posedge clk) begin
        if (ld_en)       ram[ld_addr]  <= ld_data;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    // write monitor for R5 and the write count of R3/R4
    always @(posedge clk) begin
        if (mon_clr) begin
            wr_cnt  <= 0;
            prev_we <= 1'b0;
        end else begin
            prev_we   <= mem_we;
            prev_addr <= mem_addr;
            prev_data <= mem_wdata;
            if (mem_we) begin
                wr_cnt <= wr_cnt + 1;
                if (prev_we) begin
                    mon_chk <= mon_chk + 1;
                    if (!(mem_addr == AW'(prev_addr + 1'b1) && mem_wdata > prev_data)) begin
                        mon_err <= mon_err + 1;
                        $display("FAIL R5 pair addr %0d/%0d data %0d/%0d expected addr+1 and larger data",
                                 prev_addr, mem_addr, prev_data, mem_wdata);
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int count_inv();
        int c = 0;
        for (int p = 0; p < N; p++)
            for (int q = p + 1; q < N; q++)
                if (orig[p] > orig[q]) c++;
        return c;
    endfunction

    function automatic int expect_cycles(input int inv);
        int t = 2;
        for (int i = 2; i <= N; i++) t += 5 * i - 2;
        return t + 3 * inv;
    endfunction

    task automatic build_ref();
        for (int k = 0; k < N; k++) ref_arr[k] = orig[k];
        for (int k = 1; k < N; k++) begin
            logic [W-1:0] key = ref_arr[k];
            int m = k - 1;
            while (m >= 0 && ref_arr[m] > key) begin
                ref_arr[m + 1] = ref_arr[m];
                m--;
            end
            ref_arr[m + 1] = key;
        end
    endtask

    task automatic load_ram();
        for (int k = 0; k < N; k++) begin
            ld_en = 1'b1; ld_addr = AW'(k); ld_data = orig[k];
            @(posedge clk); #1;
        end
        ld_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (!done && cycles < WAIT_LIMIT) begin
            @(posedge clk); #1;
            cycles++;
        end
        chk(done, "R2 done within limit", int'(done), 1);
    endtask

    task automatic check_sorted(input string req);
        int bad = 0;
        for (int k = 0; k < N; k++) begin
            if (ram[k] !== ref_arr[k]) begin
                bad++;
                $display("FAIL %s addr %0d actual %0d expected %0d", req, k, ram[k], ref_arr[k]);
            end
        end
        n_chk++;
        if (bad != 0) n_err++;
    endtask

    task automatic run_sort(input string name, input bit expect_no_write);
        int cyc;
        int inv;
        load_ram();
        build_ref();
        inv = count_inv();
        mon_clr = 1'b1; @(posedge clk); #1; mon_clr = 1'b0;
        pulse_start();
        chk(!done, "R6 done low after start", int'(done), 0);
        wait_done(cyc);
        check_sorted({"R2 ", name});
        chk(cyc == expect_cycles(inv), "R8 cycles to done", cyc, expect_cycles(inv));
        chk(wr_cnt == 2 * inv, "R4 write count", wr_cnt, 2 * inv);
        if (expect_no_write) chk(wr_cnt == 0, "R3 no writes on ordered input", wr_cnt, 0);
        $display("sort %s inversions %0d cycles %0d", name, inv, cyc);
    endtask

    initial begin
        #(4 * 200000);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk + mon_chk + 1, n_err + mon_err + 1);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < N; k++) ram[k] = '0;
        #9;
        chk(!done && !mem_we, "R1 reset state", int'(done), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        mon_clr = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk); #1;
            if (done || mem_we) chk(1'b0, "R1 idle outputs", int'(done) + int'(mem_we), 0);
        end
        chk(wr_cnt == 0 && !done, "R1 idle no writes", wr_cnt, 0);

        // directed: ascending with duplicates
        for (int k = 0; k < N; k++) orig[k] = W'(k / 2 * 3);
        run_sort("ascending", 1'b1);

        // R6: done holds and RAM stays put while start is low
        for (int c = 0; c < 20; c++) begin @(posedge clk); #1; end
        chk(done, "R6 done held", int'(done), 1);
        check_sorted("R6 RAM unchanged while done");

        // directed: all words equal
        for (int k = 0; k < N; k++) orig[k] = W'(8'hA5);
        run_sort("constant", 1'b1);

        // directed: strictly descending
        for (int k = 0; k < N; k++) orig[k] = W'(250 - 7 * k);
        run_sort("descending", 1'b0);

        // directed: extremes of the unsigned range
        for (int k = 0; k < N; k++) orig[k] = (k % 2 == 0) ? W'(255) : W'(0);
        run_sort("extremes", 1'b0);

        // random full range
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < N; k++) orig[k] = W'($urandom);
            run_sort("random", 1'b0);
        end

        // random with many duplicates
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < N; k++) orig[k] = W'($urandom % 4);
            run_sort("dupes", 1'b0);
        end

        // R7: restart in the middle of a sort
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < N; k++) orig[k] = W'($urandom);
            load_ram();
            pulse_start();
            for (int c = 0; c < 151 + 98 * r; c++) begin @(posedge clk); #1; end
            pulse_start();
            chk(!done, "R7 done low after restart", int'(done), 0);
            // reference is built from RAM contents at the restart point
            for (int k = 0; k < N; k++) orig[k] = ram[k];
            build_ref();
            wait_done(cyc);
            check_sorted("R7 sorted after restart");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk + mon_chk, n_err + mon_err);
        $finish;
    end

endmodule